// File: doc/BRIEF.md
# A/D Conversion Control Sequencer

This block holds the digital control of a successive-approximation A/D converter. It turns a 4-bit source field and a 4-bit channel field into one-hot enables for the analog input multiplexer. It derives a converter tick from the system clock with a power-of-two divider. It runs the bit-trial loop against a comparator result bit. The multiplexer, the DAC and the comparator stay outside; only their digital controls cross the ports.

Software starts a conversion by writing the start bit high and then low again. The conversion launches on the falling edge that follows a rising edge. A busy flag covers the whole conversion. At the end the result register loads the final code and an interrupt request flag is set. That flag stays set until a clear input removes it. The interrupt line is the flag gated by an enable.

Top module: `adc_conv_seq`

## Requirements
- R1: When `src_sel` is 0000, 0100 or 1100–1111, the source is external. Then `ext_en[k]` is 1 exactly when `chan_sel` equals k, for k in 0..5. Channel codes 6–15 leave `ext_en` all zero, and `int_src_en` is all zero.
- R2: Internal sources drive one bit of `int_src_en` and force `ext_en` to zero whatever `chan_sel` holds. The mapping is: 0001→bit0 (supply), 0010→bit1 (supply/2), 0011→bit2 (supply/4), 0101→bit3 (amplifier), 0110→bit4 (amplifier/2), 0111→bit5 (amplifier/4), 1000→bit6 (op-amp 0), 1001→bit7 (op-amp 1), 1010 and 1011→bit8 (ground).
- R3: A conversion starts only on a falling edge of `start_bit` that follows a rising edge seen while idle. Holding `start_bit` high does not start one. `busy` is 1 from the clock edge that samples the low level.
- R4: With divider select s, one converter tick is 2^s system clocks; select 111 gives 128. The divider restarts at each conversion, and `busy` stays high for exactly 14·2^s cycles.
- R5: The first 2 ticks are the sample phase, with `sample_en` high for 2·2^s cycles. Then come 12 trials, MSB first, so the first trial code on `dac_code` is 0x800. A trial keeps its bit when `cmp_in` is 1, which means the input is at or above the trial code. The final result therefore equals the input level.
- R6: `result` changes only when a conversion completes and holds its value while `busy` is high.
- R7: Start-bit edges that occur while `busy` is high are ignored, including a falling edge that arrives after the conversion ends but pairs with a rise made while busy.
- R8: `irq_flag` is set when a conversion completes and stays set until `irq_clr` is 1 at a clock edge. If both happen at the same edge, the flag is set.
- R9: `irq_out` is `irq_flag` gated by `int_en`.
- R10: After reset, `busy`, `sample_en`, `irq_flag`, `irq_out`, `result` and `dac_code` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 4 | Input source field |
| chan_sel | input | 4 | External channel field |
| div_sel | input | 3 | Converter tick divider select |
| start_bit | input | 1 | Software start bit; toggled high then low |
| int_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Clears the interrupt request flag |
| cmp_in | input | 1 | Comparator result: 1 when input ≥ DAC code |
| ext_en | output | 6 | One-hot external pin enables |
| int_src_en | output | 9 | One-hot internal source enables |
| dac_code | output | 12 | Trial code for the DAC |
| sample_en | output | 1 | Sample phase active |
| busy | output | 1 | Conversion in progress |
| result | output | 12 | Last completed conversion result |
| irq_flag | output | 1 | Interrupt request flag |
| irq_out | output | 1 | Gated interrupt line |

## Verification
The bench builds the block with its default parameters: 12 result bits, 6 external channels, a 2-tick sample phase and a 3-bit divider select. With these values every one of the 256 source/channel combinations can be reached. The full 12-bit code range can be reached at both ends, and so can the 128 division at select 111, where a conversion lasts 1792 cycles. The bench models the comparator as an ideal compare of a chosen level against `dac_code`. As a result, the final code, the MSB-first trial order and the exact busy and sample lengths are all observable at the ports.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

    localparam int SRC_W     = 4;
    localparam int CHAN_W    = 4;
    localparam int INT_SRC_N = 9;

    localparam int IDX_SUP_1  = 0;
    localparam int IDX_SUP_2  = 1;
    localparam int IDX_SUP_4  = 2;
    localparam int IDX_AMP_1  = 3;
    localparam int IDX_AMP_2  = 4;
    localparam int IDX_AMP_4  = 5;
    localparam int IDX_OPA_0  = 6;
    localparam int IDX_OPA_1  = 7;
    localparam int IDX_GROUND = 8;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SAMPLE = 2'd1,
        PH_TRIAL  = 2'd2
    } phase_e;

    typedef struct packed {
        logic                 is_internal;
        logic [INT_SRC_N-1:0] onehot;
    } src_decode_t;

    function automatic src_decode_t decode_source(input logic [SRC_W-1:0] code);
        src_decode_t d;
        d.is_internal = 1'b1;
        d.onehot      = '0;
        case (code)
            4'b0001: d.onehot[IDX_SUP_1]  = 1'b1;
            4'b0010: d.onehot[IDX_SUP_2]  = 1'b1;
            4'b0011: d.onehot[IDX_SUP_4]  = 1'b1;
            4'b0101: d.onehot[IDX_AMP_1]  = 1'b1;
            4'b0110: d.onehot[IDX_AMP_2]  = 1'b1;
            4'b0111: d.onehot[IDX_AMP_4]  = 1'b1;
            4'b1000: d.onehot[IDX_OPA_0]  = 1'b1;
            4'b1001: d.onehot[IDX_OPA_1]  = 1'b1;
            4'b1010,
            4'b1011: d.onehot[IDX_GROUND] = 1'b1;
            default: d.is_internal = 1'b0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/adcseq_src_decode.sv
module adcseq_src_decode
    import adcseq_pkg::*;
#(
    parameter int NUM_EXT = 6
) (
    input  logic [SRC_W-1:0]     src_sel,
    input  logic [CHAN_W-1:0]    chan_sel,
    output logic [NUM_EXT-1:0]   ext_en,
    output logic [INT_SRC_N-1:0] int_src_en
);
    src_decode_t dec;

    always_comb dec = decode_source(src_sel);

    assign int_src_en = dec.onehot;

    for (genvar g = 0; g < NUM_EXT; g++) begin : g_ext
        assign ext_en[g] = !dec.is_internal && (chan_sel == CHAN_W'(g));
    end

    always_comb begin
        assert_ext_onehot_R1: assert ($onehot0(ext_en));
        if (|int_src_en) begin
            assert_int_isolates_ext_R2: assert (ext_en == '0);
        end
    end
endmodule

// File: rtl/adcseq_tick_gen.sv
module adcseq_tick_gen #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div_sel,
    output logic             tick
);
    localparam int CNT_W = (1 << DIV_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   span;
    logic [CNT_W-1:0] terminal;

    always_comb begin
        span     = (CNT_W + 1)'(1) << div_sel;
        terminal = CNT_W'(span - (CNT_W + 1)'(1));
    end

    assign tick = run && (cnt_q == terminal);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) cnt_q <= '0;
        else                     cnt_q <= cnt_q + CNT_W'(1);
    end

    assert_tick_needs_run_R4: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt_q == '0));
endmodule

// File: rtl/adcseq_start_detect.sv
module adcseq_start_detect (
    input  logic clk,
    input  logic rst,
    input  logic start_bit,
    input  logic busy,
    output logic trig
);
    logic start_q;
    logic armed_q;

    assign trig = armed_q && start_q && !start_bit && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            start_q <= start_bit;
            if (busy || trig)                     armed_q <= 1'b0;
            else if (start_bit && !start_q)       armed_q <= 1'b1;
        end
    end

    assert_no_trig_busy_R7: assert property (@(posedge clk) disable iff (rst)
        busy |-> !trig);
endmodule

// File: rtl/adcseq_sar.sv
module adcseq_sar
    import adcseq_pkg::*;
#(
    parameter int RES_BITS     = 12,
    parameter int SAMPLE_TICKS = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                trig,
    input  logic                tick,
    input  logic                cmp_in,
    output logic                busy,
    output logic                sample_en,
    output logic [RES_BITS-1:0] dac_code,
    output logic [RES_BITS-1:0] result,
    output logic                done
);
    localparam int BIT_W = (RES_BITS > 1) ? $clog2(RES_BITS) : 1;
    localparam int SMP_W = $clog2(SAMPLE_TICKS + 1);
    localparam logic [BIT_W-1:0] TOP_BIT  = BIT_W'(RES_BITS - 1);
    localparam logic [SMP_W-1:0] SMP_LAST = SMP_W'(SAMPLE_TICKS - 1);

    phase_e              phase_q;
    logic [SMP_W-1:0]    smp_cnt_q;
    logic [BIT_W-1:0]    bit_q;
    logic [RES_BITS-1:0] work_q;
    logic [RES_BITS-1:0] result_q;
    logic [RES_BITS-1:0] trial;
    logic [RES_BITS-1:0] kept;

    always_comb begin
        trial = work_q | (RES_BITS'(1) << bit_q);
        kept  = cmp_in ? trial : work_q;
    end

    assign busy      = (phase_q != PH_IDLE);
    assign sample_en = (phase_q == PH_SAMPLE);
    assign dac_code  = (phase_q == PH_TRIAL) ? trial : '0;
    assign done      = (phase_q == PH_TRIAL) && tick && (bit_q == '0);
    assign result    = result_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_IDLE;
            smp_cnt_q <= '0;
            bit_q     <= '0;
            work_q    <= '0;
            result_q  <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (trig) begin
                        phase_q   <= PH_SAMPLE;
                        smp_cnt_q <= '0;
                        work_q    <= '0;
                        bit_q     <= '0;
                    end
                end
                PH_SAMPLE: begin
                    if (tick) begin
                        if (smp_cnt_q == SMP_LAST) begin
                            phase_q <= PH_TRIAL;
                            bit_q   <= TOP_BIT;
                        end else begin
                            smp_cnt_q <= smp_cnt_q + SMP_W'(1);
                        end
                    end
                end
                PH_TRIAL: begin
                    if (tick) begin
                        work_q <= kept;
                        if (bit_q == '0) begin
                            phase_q  <= PH_IDLE;
                            result_q <= kept;
                        end else begin
                            bit_q <= bit_q - BIT_W'(1);
                        end
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assert_msb_first_R5: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_TRIAL && $past(phase_q) == PH_SAMPLE)
            |-> dac_code == (RES_BITS'(1) << (RES_BITS - 1)));

    assert_result_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_SAMPLE) |=> $stable(result_q));

    assert_idle_stays_R3: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_IDLE && !trig) |=> (phase_q == PH_IDLE));
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
    import adcseq_pkg::*;
#(
    parameter int RES_BITS     = 12,
    parameter int NUM_EXT      = 6,
    parameter int SAMPLE_TICKS = 2,
    parameter int DIV_W        = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [SRC_W-1:0]     src_sel,
    input  logic [CHAN_W-1:0]    chan_sel,
    input  logic [DIV_W-1:0]     div_sel,
    input  logic                 start_bit,
    input  logic                 int_en,
    input  logic                 irq_clr,
    input  logic                 cmp_in,
    output logic [NUM_EXT-1:0]   ext_en,
    output logic [INT_SRC_N-1:0] int_src_en,
    output logic [RES_BITS-1:0]  dac_code,
    output logic                 sample_en,
    output logic                 busy,
    output logic [RES_BITS-1:0]  result,
    output logic                 irq_flag,
    output logic                 irq_out
);
    logic trig;
    logic tick;
    logic done;
    logic flag_q;

    adcseq_src_decode #(.NUM_EXT(NUM_EXT)) u_decode (
        .src_sel    (src_sel),
        .chan_sel   (chan_sel),
        .ext_en     (ext_en),
        .int_src_en (int_src_en)
    );

    adcseq_start_detect u_start (
        .clk       (clk),
        .rst       (rst),
        .start_bit (start_bit),
        .busy      (busy),
        .trig      (trig)
    );

    adcseq_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .run     (busy),
        .div_sel (div_sel),
        .tick    (tick)
    );

    adcseq_sar #(
        .RES_BITS     (RES_BITS),
        .SAMPLE_TICKS (SAMPLE_TICKS)
    ) u_sar (
        .clk       (clk),
        .rst       (rst),
        .trig      (trig),
        .tick      (tick),
        .cmp_in    (cmp_in),
        .busy      (busy),
        .sample_en (sample_en),
        .dac_code  (dac_code),
        .result    (result),
        .done      (done)
    );

    always_ff @(posedge clk) begin
        if (rst)          flag_q <= 1'b0;
        else if (done)    flag_q <= 1'b1;
        else if (irq_clr) flag_q <= 1'b0;
    end

    assign irq_flag = flag_q;
    assign irq_out  = flag_q && int_en;

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
        (done && irq_clr) |=> irq_flag);

    assert_done_ends_busy_R4: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    assert_flag_holds_R8: assert property (@(posedge clk) disable iff (rst)
        (irq_flag && !irq_clr) |=> irq_flag);
endmodule

// File: tb/test_adc_conv_seq.sv
module test_adc_conv_seq;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  src_sel;
    logic [3:0]  chan_sel;
    logic [2:0]  div_sel;
    logic        start_bit;
    logic        int_en;
    logic        irq_clr;
    logic        cmp_in;
    logic [5:0]  ext_en;
    logic [8:0]  int_src_en;
    logic [11:0] dac_code;
    logic        sample_en;
    logic        busy;
    logic [11:0] result;
    logic        irq_flag;
    logic        irq_out;
    logic [11:0] vin;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // ideal comparator model
    assign cmp_in = (vin >= dac_code);

    adc_conv_seq i_adc_conv_seq (
        .clk(clk), .rst(rst), .src_sel(src_sel), .chan_sel(chan_sel),
        .div_sel(div_sel), .start_bit(start_bit), .int_en(int_en),
        .irq_clr(irq_clr), .cmp_in(cmp_in), .ext_en(ext_en),
        .int_src_en(int_src_en), .dac_code(dac_code), .sample_en(sample_en),
        .busy(busy), .result(result), .irq_flag(irq_flag), .irq_out(irq_out)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [8:0] exp_int(input logic [3:0] s);
        case (s)
            4'd1:  return 9'b000000001;
            4'd2:  return 9'b000000010;
            4'd3:  return 9'b000000100;
            4'd5:  return 9'b000001000;
            4'd6:  return 9'b000010000;
            4'd7:  return 9'b000100000;
            4'd8:  return 9'b001000000;
            4'd9:  return 9'b010000000;
            4'd10, 4'd11: return 9'b100000000;
            default: return 9'b0;
        endcase
    endfunction

    function automatic logic [5:0] exp_ext(input logic [3:0] s, input logic [3:0] c);
        if (exp_int(s) != 9'b0) return 6'b0;
        if (c < 4'd6) return 6'(1) << c;
        return 6'b0;
    endfunction

    task automatic check_decode(input logic [3:0] s, input logic [3:0] c);
        @(negedge clk);
        src_sel = s; chan_sel = c;
        #1;
        if (exp_int(s) == 9'b0)
            check(ext_en == exp_ext(s, c), "R1", "ext_en", 32'(ext_en), 32'(exp_ext(s, c)));
        else
            check(ext_en == 6'b0, "R2", "ext_en forced off", 32'(ext_en), 32'h0);
        check(int_src_en == exp_int(s), exp_int(s) == 9'b0 ? "R1" : "R2",
              "int_src_en", 32'(int_src_en), 32'(exp_int(s)));
    endtask

    task automatic run_conv(input logic [11:0] v, input logic [2:0] sel,
                            input bit en, input bit clr_during);
        int busy_n = 0;
        int smp_n = 0;
        bit first = 1'b1;
        logic [11:0] first_code = '0;
        bit hold_ok = 1'b1;
        logic [11:0] prev;
        int d = 1 << sel;
        @(negedge clk);
        vin = v; div_sel = sel; int_en = en; irq_clr = clr_during;
        prev = result;
        start_bit = 1'b1;
        @(negedge clk);
        start_bit = 1'b0;
        @(negedge clk);
        while (busy) begin
            busy_n++;
            if (sample_en) smp_n++;
            else if (first) begin first_code = dac_code; first = 1'b0; end
            if (result !== prev) hold_ok = 1'b0;
            @(negedge clk);
        end
        irq_clr = 1'b0;
        check(busy_n == 14 * d, "R4", "busy length", busy_n, 14 * d);
        check(smp_n == 2 * d, "R5", "sample length", smp_n, 2 * d);
        check(first_code == 12'h800, "R5", "first trial code", first_code, 12'h800);
        check(result == v, "R5", "result", result, v);
        check(hold_ok, "R6", "result held while busy", 32'(hold_ok), 1);
        check(irq_flag == 1'b1, "R8", clr_during ? "set wins over clear" : "flag set",
              irq_flag, 1);
        check(irq_out == en, "R9", "irq_out gating", irq_out, en);
        @(negedge clk);
        check(irq_flag == 1'b1, "R8", "flag held", irq_flag, 1);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        check(irq_flag == 1'b0 && irq_out == 1'b0, "R8", "flag cleared", irq_flag, 0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; src_sel = '0; chan_sel = '0; div_sel = '0; start_bit = 1'b0;
        int_en = 1'b0; irq_clr = 1'b0; vin = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 0 && sample_en == 0 && irq_flag == 0 && irq_out == 0,
              "R10", "control outputs after reset", {busy, sample_en, irq_flag, irq_out}, 0);
        check(result == 0 && dac_code == 0, "R10", "data outputs after reset", result, 0);

        // exhaustive decode then random repeats
        for (int s = 0; s < 16; s++)
            for (int c = 0; c < 16; c++)
                check_decode(4'(s), 4'(c));
        for (int i = 0; i < 40; i++)
            check_decode(4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)));

        // R3: held high does not start
        @(negedge clk);
        start_bit = 1'b1;
        repeat (6) @(negedge clk);
        check(busy == 1'b0, "R3", "no start on rise alone", busy, 0);
        start_bit = 1'b0;
        @(negedge clk);
        check(busy == 1'b1, "R3", "start on falling edge", busy, 1);
        while (busy) @(negedge clk);
        irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;

        // directed corners
        run_conv(12'h000, 3'd0, 1'b1, 1'b0);
        run_conv(12'hFFF, 3'd1, 1'b0, 1'b0);
        run_conv(12'h800, 3'd0, 1'b1, 1'b1);
        run_conv(12'h7FF, 3'd7, 1'b1, 1'b0);
        run_conv(12'h001, 3'd2, 1'b0, 1'b1);

        // random conversions
        for (int i = 0; i < 12; i++)
            run_conv(12'($urandom_range(0, 4095)), 3'($urandom_range(0, 4)),
                     1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));

        // R7: toggles during busy ignored
        begin
            logic [11:0] held;
            @(negedge clk);
            vin = 12'h3A5; div_sel = 3'd3;
            start_bit = 1'b1; @(negedge clk); start_bit = 1'b0; @(negedge clk);
            repeat (20) @(negedge clk);
            start_bit = 1'b1; repeat (5) @(negedge clk); start_bit = 1'b0;
            repeat (5) @(negedge clk);
            start_bit = 1'b1;
            while (busy) @(negedge clk);
            start_bit = 1'b0;
            held = result;
            repeat (40) @(negedge clk);
            check(busy == 1'b0, "R7", "no restart from busy toggles", busy, 0);
            check(result == 12'h3A5 && result == held, "R7", "result unchanged", result, 12'h3A5);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule